// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing for a raster display from a single pixel clock. Two counters track where the raster is. A horizontal counter steps once per pixel. A vertical counter steps once per line. Decoding their values gives the horizontal and vertical sync pulses, a display-enable strobe, a vertical-retrace flag, and the current pixel and line coordinates.

Every horizontal quantity is set in granules of eight pixels, and every vertical quantity is set in whole lines. Each is written as its value minus one. A frame is laid out as the active region, followed by a single non-display stretch. The sync pulse sits inside that non-display stretch, at an offset counted from the end of the active region.

The configuration arrives on plain input pins. The block copies these pins into shadow registers only when a new frame begins, so a software write that lands partway through a frame never produces a torn frame. A separate live blank pin forces the enable output off without stopping the counters. Pixel fetch, colour handling and the host bus belong to neighbouring blocks.

Top module: `rtg_top`

## Requirements
- R1: While reset is asserted, and in the single idle cycle after it is released, de and vretrace are 0, pix_x and line_y are 0, and both syncs sit at their inactive level. With the reset-cleared shadow, that level is 1. The first frame starts with pix_x = 0 and line_y = 0 on the second clock after release.
- R2: A line holds (cfg_h_active+1)*8 active pixels followed by (cfg_h_nondisp+1)*8 non-display pixels. pix_x counts from 0 up to the line total minus one and then returns to 0.
- R3: A frame holds cfg_v_active+1 active lines followed by cfg_v_nondisp+1 non-display lines. line_y advances only on the clock where pix_x wraps to 0.
- R4: de is 1 exactly when pix_x is below the active width, line_y is below the active height, and blank is 0.
- R5: On every line, including non-display lines, the horizontal sync is active from pixel active_width + (cfg_h_sync_start+1)*8. It stays active for (cfg_h_sync_ctl[6:0]+1)*8 clocks.
- R6: The vertical sync is active for whole lines. It starts at line active_height + cfg_v_sync_start + 1 and lasts cfg_v_sync_ctl[6:0]+1 lines.
- R7: A sync pulse that would run past the end of the line (horizontal) or the end of the frame (vertical) is cut off there. It does not wrap into the next line or frame.
- R8: Bit 7 of each sync control input selects polarity. With cfg_passive = 0, bit 7 = 0 gives an active-low pulse and bit 7 = 1 gives an active-high pulse. cfg_passive = 1 swaps both cases.
- R9: vretrace is 1 exactly while line_y is at or beyond the active height of a running frame.
- R10: blank turns de off within the same cycle. It has no effect on pix_x, line_y, the syncs or vretrace.
- R11: Every cfg_* input is taken in on the first clock after reset and again only when the frame wraps. A change in the middle of a frame has no effect on the outputs until the next frame.
- R12: Horizontal values 0x4F/0x13/0x01/0x0B give an 800-pixel line with a 96-clock horizontal sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | Live override that forces de to 0 |
| cfg_passive | input | 1 | Panel type: 1 = passive, which inverts both sync polarities |
| cfg_h_active | input | GW | Active width in 8-pixel granules, minus one |
| cfg_h_nondisp | input | GW | Horizontal non-display length in granules, minus one |
| cfg_h_sync_start | input | GW | Granules from the end of active video to the start of horizontal sync, minus one |
| cfg_h_sync_ctl | input | 8 | Bit 7 = polarity; bits 6:0 = sync width in granules, minus one |
| cfg_v_active | input | LW | Active height in lines, minus one |
| cfg_v_nondisp | input | LW | Vertical non-display lines, minus one |
| cfg_v_sync_start | input | LW | Lines from the end of active video to the start of vertical sync, minus one |
| cfg_v_sync_ctl | input | 8 | Bit 7 = polarity; bits 6:0 = sync lines, minus one |
| hsync | output | 1 | Horizontal sync pin level |
| vsync | output | 1 | Vertical sync pin level |
| de | output | 1 | Display enable |
| vretrace | output | 1 | Vertical non-display status flag |
| pix_x | output | GW+5 | Horizontal counter, including the non-display pixels |
| line_y | output | LW+2 | Vertical counter, including the non-display lines |

## Verification
The properties assume that no single write makes the shadowed geometry inconsistent with a counter that is already running. This holds because the shadow registers load only at the wrap point, where both counters return to 0.

The properties also rely on blank being the only live input. Every other pin passes through the shadow registers. For that reason, the stimulus changes configuration pins only in the middle of a frame, a few nanoseconds after a clock edge. It moves blank at the same offset, so no change coincides with an edge.

The configurations used stay small enough for several whole frames to complete. They include one with sync windows that run past both totals, so the clipping case is covered.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int SYNC_CTL_W = 8;

  typedef struct packed {
    logic       pol;
    logic [6:0] wid_m1;
  } sync_ctl_t;

  // Pin level for a sync pulse given its logical state, polarity bit and panel type.
  function automatic logic pin_level(input logic active, input logic pol, input logic passive);
    logic on_lvl;
    on_lvl = pol ^ passive;
    return active ? on_lvl : ~on_lvl;
  endfunction
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
  parameter int GW = 8,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_passive,
  input  logic [GW-1:0] in_h_act,
  input  logic [GW-1:0] in_h_nd,
  input  logic [GW-1:0] in_h_ss,
  input  logic [7:0]    in_h_ctl,
  input  logic [LW-1:0] in_v_act,
  input  logic [LW-1:0] in_v_nd,
  input  logic [LW-1:0] in_v_ss,
  input  logic [7:0]    in_v_ctl,
  output logic          sh_passive,
  output logic [GW-1:0] sh_h_act,
  output logic [GW-1:0] sh_h_nd,
  output logic [GW-1:0] sh_h_ss,
  output logic [7:0]    sh_h_ctl,
  output logic [LW-1:0] sh_v_act,
  output logic [LW-1:0] sh_v_nd,
  output logic [LW-1:0] sh_v_ss,
  output logic [7:0]    sh_v_ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_passive <= 1'b0;
      sh_h_act   <= '0;
      sh_h_nd    <= '0;
      sh_h_ss    <= '0;
      sh_h_ctl   <= '0;
      sh_v_act   <= '0;
      sh_v_nd    <= '0;
      sh_v_ss    <= '0;
      sh_v_ctl   <= '0;
    end else if (load) begin
      sh_passive <= in_passive;
      sh_h_act   <= in_h_act;
      sh_h_nd    <= in_h_nd;
      sh_h_ss    <= in_h_ss;
      sh_h_ctl   <= in_h_ctl;
      sh_v_act   <= in_v_act;
      sh_v_nd    <= in_v_nd;
      sh_v_ss    <= in_v_ss;
      sh_v_ctl   <= in_v_ctl;
    end
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] tot_len,
  input  logic [CW-1:0] sync_beg,
  input  logic [CW-1:0] sync_end,
  output logic [CW-1:0] count,
  output logic          last,
  output logic          in_act,
  output logic          in_sync
);
  assign last = (count == tot_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (!run)  count <= '0;
    else if (step)  count <= last ? '0 : count + CW'(1);
  end

  // The window is cut off at the total because count never exceeds tot_len-1.
  assign in_act  = run && (count < act_len);
  assign in_sync = run && (count >= sync_beg) && (count < sync_end);
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int GW = 8,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          cfg_passive,
  input  logic [GW-1:0] cfg_h_active,
  input  logic [GW-1:0] cfg_h_nondisp,
  input  logic [GW-1:0] cfg_h_sync_start,
  input  logic [7:0]    cfg_h_sync_ctl,
  input  logic [LW-1:0] cfg_v_active,
  input  logic [LW-1:0] cfg_v_nondisp,
  input  logic [LW-1:0] cfg_v_sync_start,
  input  logic [7:0]    cfg_v_sync_ctl,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          vretrace,
  output logic [GW+4:0] pix_x,
  output logic [LW+1:0] line_y
);
  localparam int HL = GW + 5;
  localparam int VL = LW + 2;

  logic          run;
  logic          load;
  logic          sh_passive;
  logic [GW-1:0] sh_h_act, sh_h_nd, sh_h_ss;
  logic [LW-1:0] sh_v_act, sh_v_nd, sh_v_ss;
  logic [7:0]    sh_h_ctl_raw, sh_v_ctl_raw;
  sync_ctl_t     sh_h_ctl, sh_v_ctl;

  logic [HL-1:0] h_act_len, h_tot_len, h_sync_beg, h_sync_end;
  logic [VL-1:0] v_act_len, v_tot_len, v_sync_beg, v_sync_end;
  logic          h_last, v_last, h_in_act, v_in_act, h_in_sync, v_in_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  assign load = !run || (h_last && v_last);

  rtg_shadow #(.GW(GW), .LW(LW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_passive(cfg_passive),
    .in_h_act(cfg_h_active), .in_h_nd(cfg_h_nondisp),
    .in_h_ss(cfg_h_sync_start), .in_h_ctl(cfg_h_sync_ctl),
    .in_v_act(cfg_v_active), .in_v_nd(cfg_v_nondisp),
    .in_v_ss(cfg_v_sync_start), .in_v_ctl(cfg_v_sync_ctl),
    .sh_passive(sh_passive),
    .sh_h_act(sh_h_act), .sh_h_nd(sh_h_nd), .sh_h_ss(sh_h_ss), .sh_h_ctl(sh_h_ctl_raw),
    .sh_v_act(sh_v_act), .sh_v_nd(sh_v_nd), .sh_v_ss(sh_v_ss), .sh_v_ctl(sh_v_ctl_raw)
  );

  assign sh_h_ctl = sync_ctl_t'(sh_h_ctl_raw);
  assign sh_v_ctl = sync_ctl_t'(sh_v_ctl_raw);

  // Horizontal geometry: granule fields scaled by eight.
  assign h_act_len  = (HL'(sh_h_act) + HL'(1)) << 3;
  assign h_tot_len  = h_act_len + ((HL'(sh_h_nd) + HL'(1)) << 3);
  assign h_sync_beg = h_act_len + ((HL'(sh_h_ss) + HL'(1)) << 3);
  assign h_sync_end = h_sync_beg + ((HL'(sh_h_ctl.wid_m1) + HL'(1)) << 3);

  // Vertical geometry: line fields.
  assign v_act_len  = VL'(sh_v_act) + VL'(1);
  assign v_tot_len  = v_act_len + VL'(sh_v_nd) + VL'(1);
  assign v_sync_beg = v_act_len + VL'(sh_v_ss) + VL'(1);
  assign v_sync_end = v_sync_beg + VL'(sh_v_ctl.wid_m1) + VL'(1);

  rtg_axis #(.CW(HL)) u_haxis (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .act_len(h_act_len), .tot_len(h_tot_len),
    .sync_beg(h_sync_beg), .sync_end(h_sync_end),
    .count(pix_x), .last(h_last), .in_act(h_in_act), .in_sync(h_in_sync)
  );

  rtg_axis #(.CW(VL)) u_vaxis (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_last),
    .act_len(v_act_len), .tot_len(v_tot_len),
    .sync_beg(v_sync_beg), .sync_end(v_sync_end),
    .count(line_y), .last(v_last), .in_act(v_in_act), .in_sync(v_in_sync)
  );

  assign de       = h_in_act && v_in_act && !blank;
  assign vretrace = run && !v_in_act;
  assign hsync    = pin_level(h_in_sync, sh_h_ctl.pol, sh_passive);
  assign vsync    = pin_level(v_in_sync, sh_v_ctl.pol, sh_passive);
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
  parameter int HL = 13,
  parameter int VL = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          blank,
  input logic          de,
  input logic          vretrace,
  input logic          h_in_act,
  input logic          h_in_sync,
  input logic [HL-1:0] pix_x,
  input logic [VL-1:0] line_y
);
  // R10
  blank_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !de);

  // R9
  de_outside_retrace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !vretrace);

  // R5
  hsync_in_blanking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_in_sync |-> !h_in_act);

  // R3
  line_step_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_y) |-> (pix_x == '0));

  // R9
  retrace_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(line_y) |-> $stable(vretrace));

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && pix_x != '0) |-> (pix_x == HL'($past(pix_x) + HL'(1))));
endmodule

bind rtg_top rtg_chk #(.HL(GW + 5), .VL(LW + 2)) u_rtg_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .blank(blank), .de(de),
  .vretrace(vretrace), .h_in_act(h_in_act), .h_in_sync(h_in_sync),
  .pix_x(pix_x), .line_y(line_y)
);

// File: tb/rtg_top_bench.sv
module rtg_top_bench;
  localparam int GW = 8;
  localparam int LW = 10;

  logic clk = 1'b0, rst_n = 1'b0, blank = 1'b0, cfg_passive = 1'b0;
  logic [GW-1:0] cfg_h_active, cfg_h_nondisp, cfg_h_sync_start;
  logic [LW-1:0] cfg_v_active, cfg_v_nondisp, cfg_v_sync_start;
  logic [7:0]    cfg_h_sync_ctl, cfg_v_sync_ctl;
  logic hsync, vsync, de, vretrace;
  logic [GW+4:0] pix_x;
  logic [LW+1:0] line_y;

  always #5 clk = ~clk;

  rtg_top #(.GW(GW), .LW(LW)) u_rtg_top (
    .clk(clk), .rst_n(rst_n), .blank(blank), .cfg_passive(cfg_passive),
    .cfg_h_active(cfg_h_active), .cfg_h_nondisp(cfg_h_nondisp),
    .cfg_h_sync_start(cfg_h_sync_start), .cfg_h_sync_ctl(cfg_h_sync_ctl),
    .cfg_v_active(cfg_v_active), .cfg_v_nondisp(cfg_v_nondisp),
    .cfg_v_sync_start(cfg_v_sync_start), .cfg_v_sync_ctl(cfg_v_sync_ctl),
    .hsync(hsync), .vsync(vsync), .de(de), .vretrace(vretrace),
    .pix_x(pix_x), .line_y(line_y)
  );

  int checks = 0, errors = 0, frames = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Behavioural reference: raster position and frame-held settings.
  int m_run = 0, m_x = 0, m_y = 0;
  int s_ha = 0, s_hn = 0, s_hs = 0, s_hc = 0, s_va = 0, s_vn = 0, s_vs = 0, s_vc = 0, s_pas = 0;
  int hact, htot, hsb, hse, vact, vtot, vsb, vse, hon, von;

  task automatic take_cfg();
    s_ha = cfg_h_active; s_hn = cfg_h_nondisp; s_hs = cfg_h_sync_start; s_hc = cfg_h_sync_ctl;
    s_va = cfg_v_active; s_vn = cfg_v_nondisp; s_vs = cfg_v_sync_start; s_vc = cfg_v_sync_ctl;
    s_pas = cfg_passive;
  endtask

  task automatic geom();
    hact = (s_ha + 1) * 8;  htot = hact + (s_hn + 1) * 8;
    hsb = hact + (s_hs + 1) * 8;  hse = hsb + ((s_hc % 128) + 1) * 8;
    vact = s_va + 1;  vtot = vact + s_vn + 1;
    vsb = vact + s_vs + 1;  vse = vsb + (s_vc % 128) + 1;
    hon = (s_hc / 128) ^ s_pas;  von = (s_vc / 128) ^ s_pas;
  endtask

  function automatic int span(input int b, input int e, input int t);
    int lo, hi;
    lo = (b < t) ? b : t;
    hi = (e < t) ? e : t;
    return hi - lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_x = 0; m_y = 0;
      s_ha = 0; s_hn = 0; s_hs = 0; s_hc = 0; s_va = 0; s_vn = 0; s_vs = 0; s_vc = 0; s_pas = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_x = 0; m_y = 0; take_cfg();
    end else begin
      geom();
      if (m_x == htot - 1) begin
        m_x = 0;
        if (m_y == vtot - 1) begin m_y = 0; take_cfg(); end
        else m_y++;
      end else m_x++;
    end
  end

  // Per-frame interval tallies.
  int seen = 0, blank_seen = 0, mode_a = 0;
  int e_clk, e_de, e_hs, e_vs, e_rt, e_vtot, f_hon, f_von;
  int a_clk, a_de, a_hs, a_vs, a_rt;

  always @(negedge clk) begin
    if (!done) begin
      int x_de, x_hs, x_vs, x_rt;
      cyc++;
      geom();
      x_de = (m_run != 0 && m_x < hact && m_y < vact && !blank) ? 1 : 0;
      x_hs = (m_run != 0 && m_x >= hsb && m_x < hse) ? hon : 1 - hon;
      x_vs = (m_run != 0 && m_y >= vsb && m_y < vse) ? von : 1 - von;
      x_rt = (m_run != 0 && m_y >= vact) ? 1 : 0;
      chk(de == x_de, "R4 de", de, x_de);
      chk(hsync == x_hs, "R5 hsync", hsync, x_hs);
      chk(vsync == x_vs, "R6 vsync", vsync, x_vs);
      chk(vretrace == x_rt, "R9 vretrace", vretrace, x_rt);
      chk(int'(pix_x) == m_x, "R2 pix_x", pix_x, m_x);
      chk(int'(line_y) == m_y, "R3 line_y", line_y, m_y);
      if (m_run != 0) begin
        if (m_x == 0 && m_y == 0) begin
          if (seen != 0) begin
            chk(a_clk == e_clk, "R2 frame clocks", a_clk, e_clk);
            if (blank_seen == 0) chk(a_de == e_de, "R4 de clocks", a_de, e_de);
            chk(a_hs == e_hs, "R7 hsync clocks", a_hs, e_hs);
            chk(a_vs == e_vs, "R7 vsync clocks", a_vs, e_vs);
            chk(a_rt == e_rt, "R9 retrace clocks", a_rt, e_rt);
            if (mode_a != 0) begin
              chk(a_clk == 800 * e_vtot, "R12 line total", a_clk, 800 * e_vtot);
              chk(a_hs == 96 * e_vtot, "R12 hsync width", a_hs, 96 * e_vtot);
            end
            frames++;
          end
          seen = 1; blank_seen = 0;
          e_vtot = vtot; f_hon = hon; f_von = von;
          e_clk = htot * vtot; e_de = hact * vact;
          e_hs = vtot * span(hsb, hse, htot);
          e_vs = htot * span(vsb, vse, vtot);
          e_rt = (vtot - vact) * htot;
          mode_a = (s_ha == 8'h4F && s_hn == 8'h13 && s_hs == 1 && s_hc == 8'h0B) ? 1 : 0;
          a_clk = 0; a_de = 0; a_hs = 0; a_vs = 0; a_rt = 0;
        end
        if (blank) blank_seen = 1;
        a_clk++;
        a_de += int'(de);
        a_hs += (int'(hsync) == f_hon) ? 1 : 0;
        a_vs += (int'(vsync) == f_von) ? 1 : 0;
        a_rt += int'(vretrace);
      end
      if (cyc >= 190000) begin
        chk(0, "watchdog", cyc, 0);
        finish_run();
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_cfg(input int ha, hn, hs, hc, va, vn, vs, vc, pas);
    cfg_h_active = GW'(ha); cfg_h_nondisp = GW'(hn); cfg_h_sync_start = GW'(hs);
    cfg_h_sync_ctl = 8'(hc); cfg_v_active = LW'(va); cfg_v_nondisp = LW'(vn);
    cfg_v_sync_start = LW'(vs); cfg_v_sync_ctl = 8'(vc); cfg_passive = pas[0];
  endtask

  initial begin
    // 640-wide mode: 96-pixel sync, 16 front, 48 back; short vertical for run time
    set_cfg(8'h4F, 8'h13, 1, 8'h0B, 3, 10'h2C, 9, 1, 0);
    step(3);
    @(negedge clk);
    // R1 reset state
    chk(de == 1'b0 && vretrace == 1'b0, "R1 reset de/vretrace", {de, vretrace}, 0);
    chk(pix_x == '0 && line_y == '0, "R1 reset counters", pix_x + line_y, 0);
    chk(hsync == 1'b1 && vsync == 1'b1, "R1 reset sync idle", {hsync, vsync}, 3);
    @(posedge clk); #2 rst_n = 1'b1;
    step(1);
    @(negedge clk);
    chk(pix_x == '0 && line_y == '0 && de == 1'b1, "R1 first pixel", pix_x, 0);
    step(1000);
    // R11 mid-frame rewrite to the 832-wide mode, high-going sync
    set_cfg(8'h4F, 8'h17, 2, 8'h84, 4, 10'h27, 8, 2, 0);
    wait (frames == 1);
    step(1000);
    // R7 R8 clipped windows on a passive panel
    set_cfg(1, 1, 0, 8'h83, 2, 2, 1, 8'h85, 1);
    wait (frames == 2);
    step(70);
    // R10 blank mid-frame
    blank = 1'b1;
    step(20);
    blank = 1'b0;
    // R11 rewrite mid-frame again
    set_cfg(2, 0, 0, 8'h00, 1, 3, 0, 8'h01, 0);
    wait (frames == 5);
    step(5);
    finish_run();
  end
endmodule